// File: doc/BRIEF.md
# Vector Element Displacement Generator

This block produces the per-element displacement for a vectorised load or store whose address is formed from a base register plus an immediate. A scalar instruction carries one immediate; when it is repeated over vector elements, and over the sub-elements of each element, every repetition needs its own displacement. The block takes the raw immediate field, the instruction form, the stride mode, the access kind and the current loop position, and returns the displacement to substitute together with a flag that says whether substitution applies.

The loop position is flattened into one element index: the element step multiplied by the group size (sub-vector length plus one), plus the sub-element step. Loads take the source-side steps, or an externally remapped index when remapping is active. Stores always take the destination-side steps. Unit-stride mode adds the index times the access length to the immediate; element-stride mode multiplies the immediate by the index. For the scaled immediate form the result is divided back by four before it leaves. Address addition and the memory access itself belong to the load/store unit that consumes the result.

Top module: `vec_disp_gen`

## Requirements
- R1: With dispForm=0 the immediate is immField sign-extended from bit 15 to 32 bits; with strideMode=0 (plain) that value appears on dispOut and replaceOut is 0.
- R2: With dispForm=1 the immediate is immField[13:0] shifted left by 2 and sign-extended from bit 15; immField[15:14] have no effect; in plain mode this value appears on dispOut.
- R3: For accessKind=1 (load) with remapOn=0 the element index is srcStep*(subVl+1)+srcSub.
- R4: For a load with remapOn=1 the element index is remapIdx and the source steps have no effect.
- R5: For accessKind=2 (store) the element index is dstStep*(subVl+1)+dstSub, whatever remapOn and remapIdx are.
- R6: With strideMode=1 (unit stride) the result is imm + index*accessLen modulo 2^32 and replaceOut is 1.
- R7: With strideMode=2 (element stride) the result is imm*index modulo 2^32 (two's complement) and replaceOut is 1.
- R8: When replaceOut is 1 and dispForm=1 the 32-bit result is shifted right logically by 2 before output.
- R9: For accessKind=0 or 3 (neither load nor store) the element index is 0.
- R10: strideMode=3 behaves exactly as plain mode.
- R11: With REG_OUT=1 the outputs reflect the inputs of the previous rising clock edge; while rstN is low dispOut and replaceOut are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register |
| rstN | input | 1 | Active-low synchronous reset of the output register |
| immField | input | 16 | Raw immediate field from the instruction |
| dispForm | input | 1 | 0: full 16-bit immediate, 1: 14-bit immediate scaled by 4 |
| strideMode | input | 2 | 0 plain, 1 unit stride, 2 element stride, 3 plain |
| accessKind | input | 2 | 0 other, 1 load, 2 store, 3 other |
| srcStep | input | 7 | Source element step |
| dstStep | input | 7 | Destination element step |
| srcSub | input | 2 | Source sub-element step |
| dstSub | input | 2 | Destination sub-element step |
| subVl | input | 2 | Sub-vector length minus one |
| accessLen | input | 4 | Access size in bytes (1, 2, 4 or 8) |
| remapIdx | input | 7 | Remapped source index |
| remapOn | input | 1 | Use remapIdx for loads |
| dispOut | output | 32 | Replacement displacement |
| replaceOut | output | 1 | Displacement must replace the instruction immediate |

## Verification
Loads are driven with remapping on and off and with differing source and destination steps, so a swapped step selection or a remap leaking into stores shows as a wrong displacement. Sub-vector lengths of 0 and 3 with non-zero sub-steps separate a correct group size from an off-by-one one, and the largest steps with an 8-byte access reach the top of the index range. Negative immediates in both forms under both stride modes tell sign extension, wrap-around and a logical from an arithmetic final shift apart, while the neither-load-nor-store kinds and the reserved stride code confirm the zero index and the plain pass-through.

// File: rtl/vdisp_pkg.sv
`timescale 1ns/1ps
package vdisp_pkg;

  typedef enum logic [1:0] {
    STRIDE_PLAIN = 2'd0,
    STRIDE_UNIT  = 2'd1,
    STRIDE_ELEM  = 2'd2,
    STRIDE_RSVD  = 2'd3
  } strideE;

  typedef enum logic [1:0] {
    ACC_OTHER  = 2'd0,
    ACC_LOAD   = 2'd1,
    ACC_STORE  = 2'd2,
    ACC_OTHER3 = 2'd3
  } accessE;

  // strobes from control to datapath
  typedef struct packed {
    logic pickSrc;    // flattened source steps as index
    logic pickDst;    // flattened destination steps as index
    logic pickRemap;  // remapped index
    logic addMode;    // imm + index*len
    logic mulMode;    // imm * index
    logic doReplace;  // result replaces immediate
    logic dsRescale;  // divide result by four
  } ctrlS;

endpackage

// File: rtl/vdisp_ctrl.sv
`timescale 1ns/1ps
module vdisp_ctrl
  import vdisp_pkg::*;
(
  input  logic [1:0] strideMode,
  input  logic [1:0] accessKind,
  input  logic       remapOn,
  input  logic       dispForm,
  output ctrlS       ctrl
);

  strideE strideSel;
  accessE accessSel;

  assign strideSel = strideE'(strideMode);
  assign accessSel = accessE'(accessKind);

  always_comb begin
    ctrl = '0;
    unique case (accessSel)
      ACC_LOAD: begin
        ctrl.pickRemap = remapOn;
        ctrl.pickSrc   = !remapOn;
      end
      ACC_STORE: ctrl.pickDst = 1'b1;
      default: ;
    endcase
    unique case (strideSel)
      STRIDE_UNIT: ctrl.addMode = 1'b1;
      STRIDE_ELEM: ctrl.mulMode = 1'b1;
      default: ;
    endcase
    ctrl.doReplace = ctrl.addMode || ctrl.mulMode;
    ctrl.dsRescale = ctrl.doReplace && dispForm;
  end

endmodule

// File: rtl/vdisp_flat.sv
`timescale 1ns/1ps
module vdisp_flat #(
  parameter int STEP_W = 7,
  parameter int SUB_W  = 2,
  localparam int IDX_W = STEP_W + SUB_W
) (
  input  logic [STEP_W-1:0] step,
  input  logic [SUB_W-1:0]  sub,
  input  logic [SUB_W-1:0]  subVl,
  output logic [IDX_W-1:0]  idx
);

  logic [SUB_W:0]   groupSize;
  logic [IDX_W-1:0] stepX;
  logic [IDX_W-1:0] groupX;
  logic [IDX_W-1:0] subX;

  assign groupSize = {1'b0, subVl} + (SUB_W+1)'(1);
  assign stepX     = {{SUB_W{1'b0}}, step};
  assign groupX    = {{(IDX_W-SUB_W-1){1'b0}}, groupSize};
  assign subX      = {{STEP_W{1'b0}}, sub};
  assign idx       = stepX * groupX + subX;

endmodule

// File: rtl/vdisp_dp.sv
`timescale 1ns/1ps
module vdisp_dp
  import vdisp_pkg::*;
#(
  parameter int FIELD_W = 16,
  parameter int DISP_W  = 32,
  parameter int STEP_W  = 7,
  parameter int SUB_W   = 2,
  parameter int LEN_W   = 4,
  localparam int IDX_W  = STEP_W + SUB_W
) (
  input  logic [FIELD_W-1:0] immField,
  input  logic               dispForm,
  input  logic [STEP_W-1:0]  srcStep,
  input  logic [STEP_W-1:0]  dstStep,
  input  logic [SUB_W-1:0]   srcSub,
  input  logic [SUB_W-1:0]   dstSub,
  input  logic [SUB_W-1:0]   subVl,
  input  logic [LEN_W-1:0]   accessLen,
  input  logic [STEP_W-1:0]  remapIdx,
  input  ctrlS               ctrl,
  output logic [DISP_W-1:0]  dispComb
);

  logic [FIELD_W-1:0] immRaw;
  logic [DISP_W-1:0]  immExt;
  logic [STEP_W-1:0]  stepArr [2];
  logic [SUB_W-1:0]   subArr  [2];
  logic [IDX_W-1:0]   idxArr  [2];
  logic [IDX_W-1:0]   elemIdx;
  logic [DISP_W-1:0]  idxExt;
  logic [DISP_W-1:0]  lenExt;
  logic [DISP_W-1:0]  unitVal;
  logic [DISP_W-1:0]  elemVal;
  logic [DISP_W-1:0]  strided;

  // immediate extraction: scaled form drops the two top field bits
  assign immRaw = dispForm ? {immField[FIELD_W-3:0], 2'b00} : immField;
  assign immExt = {{(DISP_W-FIELD_W){immRaw[FIELD_W-1]}}, immRaw};

  assign stepArr[0] = srcStep;
  assign stepArr[1] = dstStep;
  assign subArr[0]  = srcSub;
  assign subArr[1]  = dstSub;

  for (genvar side = 0; side < 2; side++) begin : g_flat
    vdisp_flat #(.STEP_W(STEP_W), .SUB_W(SUB_W)) uFlat (
      .step (stepArr[side]),
      .sub  (subArr[side]),
      .subVl(subVl),
      .idx  (idxArr[side])
    );
  end

  always_comb begin
    elemIdx = '0;
    if (ctrl.pickSrc)   elemIdx = idxArr[0];
    if (ctrl.pickDst)   elemIdx = idxArr[1];
    if (ctrl.pickRemap) elemIdx = {{SUB_W{1'b0}}, remapIdx};
  end

  assign idxExt  = {{(DISP_W-IDX_W){1'b0}}, elemIdx};
  assign lenExt  = {{(DISP_W-LEN_W){1'b0}}, accessLen};
  assign unitVal = immExt + idxExt * lenExt;
  assign elemVal = immExt * idxExt;

  always_comb begin
    strided = immExt;
    if (ctrl.addMode) strided = unitVal;
    if (ctrl.mulMode) strided = elemVal;
  end

  assign dispComb = ctrl.dsRescale ? {2'b00, strided[DISP_W-1:2]} : strided;

endmodule

// File: rtl/vec_disp_gen.sv
`timescale 1ns/1ps
module vec_disp_gen
  import vdisp_pkg::*;
#(
  parameter int FIELD_W = 16,
  parameter int DISP_W  = 32,
  parameter int STEP_W  = 7,
  parameter int SUB_W   = 2,
  parameter int LEN_W   = 4,
  parameter bit REG_OUT = 1'b1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FIELD_W-1:0] immField,
  input  logic               dispForm,
  input  logic [1:0]         strideMode,
  input  logic [1:0]         accessKind,
  input  logic [STEP_W-1:0]  srcStep,
  input  logic [STEP_W-1:0]  dstStep,
  input  logic [SUB_W-1:0]   srcSub,
  input  logic [SUB_W-1:0]   dstSub,
  input  logic [SUB_W-1:0]   subVl,
  input  logic [LEN_W-1:0]   accessLen,
  input  logic [STEP_W-1:0]  remapIdx,
  input  logic               remapOn,
  output logic [DISP_W-1:0]  dispOut,
  output logic               replaceOut
);

  ctrlS              ctrl;
  logic [DISP_W-1:0] dispComb;

  vdisp_ctrl uCtrl (
    .strideMode(strideMode),
    .accessKind(accessKind),
    .remapOn   (remapOn),
    .dispForm  (dispForm),
    .ctrl      (ctrl)
  );

  vdisp_dp #(
    .FIELD_W(FIELD_W), .DISP_W(DISP_W), .STEP_W(STEP_W),
    .SUB_W(SUB_W), .LEN_W(LEN_W)
  ) uDp (
    .immField (immField),
    .dispForm (dispForm),
    .srcStep  (srcStep),
    .dstStep  (dstStep),
    .srcSub   (srcSub),
    .dstSub   (dstSub),
    .subVl    (subVl),
    .accessLen(accessLen),
    .remapIdx (remapIdx),
    .ctrl     (ctrl),
    .dispComb (dispComb)
  );

  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rstN) begin
        dispOut    <= '0;
        replaceOut <= 1'b0;
      end else begin
        dispOut    <= dispComb;
        replaceOut <= ctrl.doReplace;
      end
    end
  end else begin : g_comb
    assign dispOut    = dispComb;
    assign replaceOut = ctrl.doReplace;
  end

endmodule

// File: rtl/vdisp_chk.sv
`timescale 1ns/1ps
module vdisp_chk #(
  parameter int FIELD_W = 16,
  parameter int DISP_W  = 32,
  parameter bit REG_OUT = 1'b1
) (
  input logic               clk,
  input logic               rstN,
  input logic [FIELD_W-1:0] immField,
  input logic               dispForm,
  input logic [1:0]         strideMode,
  input logic [1:0]         accessKind,
  input logic [DISP_W-1:0]  dispOut,
  input logic               replaceOut
);

  logic [FIELD_W-1:0] seenField;
  logic               seenForm;
  logic [1:0]         seenStride;
  logic [1:0]         seenKind;
  logic               primed;

  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk) begin
      if (!rstN) begin
        seenField  <= '0;
        seenForm   <= 1'b0;
        seenStride <= 2'd0;
        seenKind   <= 2'd0;
      end else begin
        seenField  <= immField;
        seenForm   <= dispForm;
        seenStride <= strideMode;
        seenKind   <= accessKind;
      end
    end
  end else begin : g_live
    assign seenField  = immField;
    assign seenForm   = dispForm;
    assign seenStride = strideMode;
    assign seenKind   = accessKind;
  end

  always_ff @(posedge clk) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  AST_PLAIN_NO_REPLACE: assert property (@(posedge clk) disable iff (!rstN)
    primed && seenStride == 2'd0 |-> !replaceOut); // R1

  AST_PLAIN_D_PASS: assert property (@(posedge clk) disable iff (!rstN)
    primed && seenStride == 2'd0 && !seenForm
      |-> dispOut == {{(DISP_W-FIELD_W){seenField[FIELD_W-1]}}, seenField}); // R1

  AST_RSVD_NO_REPLACE: assert property (@(posedge clk) disable iff (!rstN)
    primed && seenStride == 2'd3 |-> !replaceOut); // R10

  AST_STRIDE_REPLACES: assert property (@(posedge clk) disable iff (!rstN)
    primed && (seenStride == 2'd1 || seenStride == 2'd2) |-> replaceOut); // R6

  AST_DS_TOP_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    primed && replaceOut && seenForm |-> dispOut[DISP_W-1:DISP_W-2] == 2'b00); // R8

  AST_NONMEM_ELEM_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    primed && seenStride == 2'd2 && (seenKind == 2'd0 || seenKind == 2'd3)
      |-> dispOut == '0); // R9

endmodule

bind vec_disp_gen vdisp_chk #(
  .FIELD_W(FIELD_W), .DISP_W(DISP_W), .REG_OUT(REG_OUT)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .immField  (immField),
  .dispForm  (dispForm),
  .strideMode(strideMode),
  .accessKind(accessKind),
  .dispOut   (dispOut),
  .replaceOut(replaceOut)
);

// File: tb/tb_vec_disp_gen.sv
`timescale 1ns/1ps
module tb_vec_disp_gen;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] immField = '0;
  logic        dispForm = 1'b0;
  logic [1:0]  strideMode = '0;
  logic [1:0]  accessKind = '0;
  logic [6:0]  srcStep = '0;
  logic [6:0]  dstStep = '0;
  logic [1:0]  srcSub = '0;
  logic [1:0]  dstSub = '0;
  logic [1:0]  subVl = '0;
  logic [3:0]  accessLen = 4'd1;
  logic [6:0]  remapIdx = '0;
  logic        remapOn = 1'b0;
  logic [31:0] dispOut;
  logic        replaceOut;

  int testCnt = 0;
  int failCnt = 0;
  int cyc = 0;
  bit allSent = 1'b0;

  logic [32:0] expQ[$];
  int          dueQ[$];
  string       tagQ[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  vec_disp_gen dut (
    .clk(clk), .rstN(rstN), .immField(immField), .dispForm(dispForm),
    .strideMode(strideMode), .accessKind(accessKind), .srcStep(srcStep),
    .dstStep(dstStep), .srcSub(srcSub), .dstSub(dstSub), .subVl(subVl),
    .accessLen(accessLen), .remapIdx(remapIdx), .remapOn(remapOn),
    .dispOut(dispOut), .replaceOut(replaceOut)
  );

  // reference model written from the requirements
  function automatic logic [32:0] model(
    input logic [15:0] fld, input logic frm, input logic [1:0] sm,
    input logic [1:0] ak, input int ss, input int ds, input int ssb,
    input int dsb, input int sv, input int len, input int rIdx, input logic rOn);
    longint imm, idx, res;
    logic [31:0] r32;
    logic rep;
    if (frm) imm = longint'($signed({fld[13:0], 2'b00}));
    else     imm = longint'($signed(fld));
    if (ak == 2'd1)      idx = rOn ? rIdx : ss * (sv + 1) + ssb;
    else if (ak == 2'd2) idx = ds * (sv + 1) + dsb;
    else                 idx = 0;
    rep = (sm == 2'd1) || (sm == 2'd2);
    if (sm == 2'd1)      res = imm + idx * len;
    else if (sm == 2'd2) res = imm * idx;
    else                 res = imm;
    r32 = res[31:0];
    if (rep && frm) r32 = r32 >> 2;
    return {rep, r32};
  endfunction

  task automatic drive(input string tag, input logic [15:0] fld, input logic frm,
    input logic [1:0] sm, input logic [1:0] ak, input int ss, input int ds,
    input int ssb, input int dsb, input int sv, input int len,
    input int rIdx, input logic rOn);
    @(posedge clk);
    #2;
    immField = fld; dispForm = frm; strideMode = sm; accessKind = ak;
    srcStep = 7'(ss); dstStep = 7'(ds); srcSub = 2'(ssb); dstSub = 2'(dsb);
    subVl = 2'(sv); accessLen = 4'(len); remapIdx = 7'(rIdx); remapOn = rOn;
    expQ.push_back(model(fld, frm, sm, ak, ss, ds, ssb, dsb, sv, len, rIdx, rOn));
    dueQ.push_back(cyc + 1);
    tagQ.push_back(tag);
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(posedge clk);
      #6;
      while (expQ.size() > 0 && dueQ[0] <= cyc) begin
        logic [32:0] e;
        string t;
        e = expQ.pop_front();
        void'(dueQ.pop_front());
        t = tagQ.pop_front();
        testCnt++;
        if ({replaceOut, dispOut} !== e) begin
          failCnt++;
          $display("FAIL %s: got rep=%0b disp=%08h, expected rep=%0b disp=%08h",
                   t, replaceOut, dispOut, e[32], e[31:0]);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    failCnt++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #6;
    testCnt++;
    if (dispOut !== 32'h0 || replaceOut !== 1'b0) begin
      failCnt++;
      $display("FAIL R11 reset: got %08h/%0b, expected 00000000/0", dispOut, replaceOut);
    end
    @(posedge clk); #2; rstN = 1'b1;

    // R1 plain D-form pass-through, positive and negative
    drive("R1 plain pos", 16'h1234, 0, 2'd0, 2'd1, 5, 6, 1, 2, 3, 8, 9, 0);
    drive("R1 plain neg", 16'hFFF0, 0, 2'd0, 2'd2, 5, 6, 1, 2, 3, 8, 9, 0);
    // R2 DS form, top field bits ignored
    drive("R2 ds plain", 16'hC005, 1, 2'd0, 2'd1, 1, 1, 0, 0, 0, 4, 0, 0);
    drive("R2 ds neg",   16'h3FFF, 1, 2'd0, 2'd1, 1, 1, 0, 0, 0, 4, 0, 0);
    // R3 load flattening, subVl 0 and 3
    drive("R3 load sv0", 16'h0010, 0, 2'd1, 2'd1, 9, 2, 0, 0, 0, 4, 50, 0);
    drive("R3 load sv3", 16'h0010, 0, 2'd1, 2'd1, 9, 2, 2, 1, 3, 4, 50, 0);
    drive("R3 load max", 16'h0000, 0, 2'd1, 2'd1, 127, 0, 3, 0, 3, 8, 0, 0);
    // R4 remap on a load
    drive("R4 remap load", 16'h0008, 0, 2'd1, 2'd1, 9, 2, 2, 1, 3, 2, 77, 1);
    drive("R4 remap elem", 16'h0003, 0, 2'd2, 2'd1, 9, 2, 2, 1, 3, 2, 13, 1);
    // R5 store ignores remap
    drive("R5 store", 16'h0004, 0, 2'd1, 2'd2, 9, 11, 3, 2, 1, 8, 77, 1);
    drive("R5 store elem", 16'hFFFE, 0, 2'd2, 2'd2, 40, 30, 0, 3, 3, 1, 5, 0);
    // R6 unit stride with negative immediate and wrap
    drive("R6 unit neg", 16'h8000, 0, 2'd1, 2'd1, 3, 0, 0, 0, 0, 1, 0, 0);
    drive("R6 unit len8", 16'hFFFF, 0, 2'd1, 2'd2, 0, 100, 0, 1, 1, 8, 0, 0);
    // R7 element stride
    drive("R7 elem pos", 16'h0100, 0, 2'd2, 2'd1, 7, 0, 1, 0, 1, 4, 0, 0);
    drive("R7 elem neg", 16'hFF00, 0, 2'd2, 2'd1, 127, 0, 3, 0, 3, 4, 0, 0);
    // R8 DS form with replacement: logical shift
    drive("R8 ds unit neg", 16'h3FF0, 1, 2'd1, 2'd1, 2, 0, 0, 0, 0, 8, 0, 0);
    drive("R8 ds elem",     16'h0007, 1, 2'd2, 2'd2, 0, 5, 0, 1, 1, 4, 0, 0);
    drive("R8 ds elem neg", 16'h2001, 1, 2'd2, 2'd1, 3, 0, 0, 0, 0, 2, 0, 0);
    // R9 neither load nor store
    drive("R9 other0 unit", 16'h0040, 0, 2'd1, 2'd0, 20, 20, 1, 1, 2, 8, 9, 1);
    drive("R9 other3 elem", 16'h0040, 0, 2'd2, 2'd3, 20, 20, 1, 1, 2, 8, 9, 1);
    // R10 reserved stride code
    drive("R10 rsvd", 16'hABCD, 0, 2'd3, 2'd1, 20, 20, 1, 1, 2, 8, 9, 0);
    drive("R10 rsvd ds", 16'h0ABC, 1, 2'd3, 2'd2, 20, 20, 1, 1, 2, 8, 9, 0);
    // R11 back-to-back latency already exercised; idle change
    drive("R11 hold", 16'h0001, 0, 2'd1, 2'd1, 1, 1, 0, 0, 0, 1, 0, 0);
    allSent = 1'b1;
    repeat (4) @(posedge clk);
    #7;
    if (expQ.size() != 0) begin
      failCnt++;
      $display("FAIL R11 drain: got %0d pending, expected 0", expQ.size());
    end
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

endmodule